// File: doc/BRIEF.md
# Receive-Level Flow-Control Character Generator

This block watches how full the receive buffer is and asks the transmitter to send flow-control characters to the far end. The buffer reaches the selected threshold. After two character times, the block requests the stop character or characters. It then waits until the fill has drained to the next lower threshold step before it requests the resume character or characters. Raising the threshold for stop and lowering it for resume gives hysteresis, so the link does not toggle between stop and resume on every character.

The character time comes from an external tick pulse, one pulse per character frame. The delay therefore follows the configured baud rate and frame length without any divider inside this block. The transmitter takes characters over a request/acknowledge handshake. It accepts one only at a character boundary and gives it priority over normal queued data. In double mode, each event produces a pair of characters. In single mode, it produces only the first character of the pair.

Top module: `rxlvl_flow_gen`

## Requirements
- R1: After reset, `fc_req` is 0.
- R2: The stop request is timed from the crossing. The crossing happens when `lvl_en` is 1 and `rx_fill` is at or above the selected threshold. `fc_req` stays 0 through the first `char_tick` after the crossing. It rises in the same clock cycle that registers the second `char_tick`.
- R3: While `lvl_en` is 0, no stop request is made, however full the buffer is.
- R4: The stop request sends `stop_a` first. In double mode (`pair_mode` = 1), `stop_b` follows after `stop_a` is acknowledged. In single mode, the request drops after the first acknowledge.
- R5: While `fc_req` is 1 and `fc_ack` is 0, both `fc_req` and `fc_char` keep their values.
- R6: A stop has been sent. The resume request is made only when `rx_fill` is at or below the lower step for the selected threshold: 60→56, 56→16, 16→8, 8→0. It rises one cycle after that fill is presented. A fill one above the lower step gives no request.
- R7: The resume request sends `go_a` first. In double mode, `go_b` follows. The request drops after the last acknowledge.
- R8: Only one stop is sent per crossing. While the fill stays high after a stop, further ticks make no new request until a resume has been sent.
- R9: The fill may fall to the lower step before the second tick. In that case the pending stop is cancelled, and no stop or resume is requested.
- R10: `thr_sel` encodes the threshold as 0→8, 1→16, 2→56, 3→60. A fill one below the threshold starts no delay.
- R11: An `fc_ack` pulse while `fc_req` is 0 has no effect. The next stop still begins with `stop_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_fill | input | 7 | Current receive buffer fill count |
| thr_sel | input | 2 | Threshold select: 0=8, 1=16, 2=56, 3=60 |
| lvl_en | input | 1 | Enables automatic stop/resume generation |
| pair_mode | input | 1 | 1 = two characters per event, 0 = one |
| stop_a | input | 8 | First stop character |
| stop_b | input | 8 | Second stop character |
| go_a | input | 8 | First resume character |
| go_b | input | 8 | Second resume character |
| char_tick | input | 1 | One-cycle pulse per character time |
| fc_req | output | 1 | Flow-control character waiting to be sent |
| fc_char | output | 8 | Character to send while `fc_req` is 1 |
| fc_ack | input | 1 | Transmitter took `fc_char` at a character boundary |

## Verification
Each result has its own due cycle:
- The stop request is due in the cycle that registers the second tick after the crossing, and never sooner.
- The resume request is due one cycle after the drained fill is presented.
- After each acknowledge, the next character of the pair, or the dropped request, is due one cycle later.

The bench drives inputs on the falling edge and reads outputs on the next falling edge. Every check therefore falls exactly one register stage after its stimulus. Checks placed before the due cycle confirm that nothing happened early. The sweep covers all four thresholds in both character modes.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

  localparam int LVL_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND_OFF,
    ST_HOLD,
    ST_SEND_ON
  } xfc_state_e;

  function automatic logic [LVL_W-1:0] upper_step(input logic [1:0] sel);
    case (sel)
      2'd0:    upper_step = 7'd8;
      2'd1:    upper_step = 7'd16;
      2'd2:    upper_step = 7'd56;
      default: upper_step = 7'd60;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] lower_step(input logic [1:0] sel);
    case (sel)
      2'd0:    lower_step = 7'd0;
      2'd1:    lower_step = 7'd8;
      2'd2:    lower_step = 7'd16;
      default: lower_step = 7'd56;
    endcase
  endfunction

endpackage

// File: rtl/xfc_thresh.sv
module xfc_thresh
  import xfc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] fill,
  input  logic [1:0]       sel,
  output logic             at_upper,
  output logic             at_lower
);
  localparam int EXT = CNT_W - LVL_W;

  logic [CNT_W-1:0] up_lvl;
  logic [CNT_W-1:0] lo_lvl;

  assign up_lvl   = {{EXT{1'b0}}, upper_step(sel)};
  assign lo_lvl   = {{EXT{1'b0}}, lower_step(sel)};
  assign at_upper = (fill >= up_lvl);
  assign at_lower = (fill <= lo_lvl);
endmodule

// File: rtl/xfc_delay.sv
module xfc_delay #(
  parameter int DELAY_CHARS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(DELAY_CHARS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CHARS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (tick)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign done = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/xfc_ctrl.sv
module xfc_ctrl
  import xfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pair,
  input  logic              at_upper,
  input  logic              at_lower,
  input  logic              delay_done,
  input  logic [DATA_W-1:0] off_a,
  input  logic [DATA_W-1:0] off_b,
  input  logic [DATA_W-1:0] on_a,
  input  logic [DATA_W-1:0] on_b,
  input  logic              ack,
  output logic              waiting,
  output logic              sending_off,
  output logic              seq_idx,
  output logic              req,
  output logic [DATA_W-1:0] char_out
);
  xfc_state_e st_q, st_d;
  logic       idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_IDLE: begin
        if (en && at_upper)
          st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!en || at_lower)
          st_d = ST_IDLE;
        else if (delay_done) begin
          st_d  = ST_SEND_OFF;
          idx_d = 1'b0;
        end
      end
      ST_SEND_OFF: begin
        if (ack) begin
          if (pair && !idx_q)
            idx_d = 1'b1;
          else begin
            st_d  = ST_HOLD;
            idx_d = 1'b0;
          end
        end
      end
      ST_HOLD: begin
        if (at_lower)
          st_d = ST_SEND_ON;
      end
      ST_SEND_ON: begin
        if (ack) begin
          if (pair && !idx_q)
            idx_d = 1'b1;
          else begin
            st_d  = ST_IDLE;
            idx_d = 1'b0;
          end
        end
      end
      default: begin
        st_d  = ST_IDLE;
        idx_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign waiting     = (st_q == ST_WAIT);
  assign sending_off = (st_q == ST_SEND_OFF);
  assign seq_idx     = idx_q;
  assign req         = (st_q == ST_SEND_OFF) || (st_q == ST_SEND_ON);

  always_comb begin
    if (st_q == ST_SEND_OFF)
      char_out = idx_q ? off_b : off_a;
    else
      char_out = idx_q ? on_b : on_a;
  end
endmodule

// File: rtl/rxlvl_flow_gen.sv
module rxlvl_flow_gen #(
  parameter int CNT_W       = 7,
  parameter int DATA_W      = 8,
  parameter int DELAY_CHARS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_fill,
  input  logic [1:0]        thr_sel,
  input  logic              lvl_en,
  input  logic              pair_mode,
  input  logic [DATA_W-1:0] stop_a,
  input  logic [DATA_W-1:0] stop_b,
  input  logic [DATA_W-1:0] go_a,
  input  logic [DATA_W-1:0] go_b,
  input  logic              char_tick,
  output logic              fc_req,
  output logic [DATA_W-1:0] fc_char,
  input  logic              fc_ack
);
  logic at_upper_w;
  logic at_lower_w;
  logic waiting_w;
  logic done_w;
  logic send_off_w;
  logic idx_w;

  xfc_thresh #(.CNT_W(CNT_W)) u_thresh (
    .fill     (rx_fill),
    .sel      (thr_sel),
    .at_upper (at_upper_w),
    .at_lower (at_lower_w)
  );

  xfc_delay #(.DELAY_CHARS(DELAY_CHARS)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (waiting_w),
    .tick  (char_tick),
    .done  (done_w)
  );

  xfc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (lvl_en),
    .pair        (pair_mode),
    .at_upper    (at_upper_w),
    .at_lower    (at_lower_w),
    .delay_done  (done_w),
    .off_a       (stop_a),
    .off_b       (stop_b),
    .on_a        (go_a),
    .on_b        (go_b),
    .ack         (fc_ack),
    .waiting     (waiting_w),
    .sending_off (send_off_w),
    .seq_idx     (idx_w),
    .req         (fc_req),
    .char_out    (fc_char)
  );
endmodule

// File: rtl/rxlvl_flow_gen_chk.sv
module rxlvl_flow_gen_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              char_tick,
  input logic              pair_mode,
  input logic              fc_req,
  input logic              fc_ack,
  input logic [DATA_W-1:0] fc_char,
  input logic              send_off,
  input logic              idx
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && !fc_ack) |=> fc_req);

  // R5
  char_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && !fc_ack) |=> $stable(fc_char));

  // R2
  stop_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_off) |-> $past(char_tick));

  // R4
  single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && fc_ack && !pair_mode) |=> !fc_req);

  // R7
  pair_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && fc_ack && pair_mode && !idx) |=> (fc_req && idx));
endmodule

bind rxlvl_flow_gen rxlvl_flow_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .char_tick (char_tick),
  .pair_mode (pair_mode),
  .fc_req    (fc_req),
  .fc_ack    (fc_ack),
  .fc_char   (fc_char),
  .send_off  (send_off_w),
  .idx       (idx_w)
);

// File: tb/test_rxlvl_flow_gen.sv
`timescale 1ns/1ps
module test_rxlvl_flow_gen;
  localparam logic [7:0] S_A = 8'h13;
  localparam logic [7:0] S_B = 8'h93;
  localparam logic [7:0] G_A = 8'h11;
  localparam logic [7:0] G_B = 8'h91;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] rx_fill;
  logic [1:0] thr_sel;
  logic       lvl_en, pair_mode, char_tick, fc_ack;
  logic       fc_req;
  logic [7:0] fc_char;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  rxlvl_flow_gen i_rxlvl_flow_gen (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .thr_sel(thr_sel),
    .lvl_en(lvl_en), .pair_mode(pair_mode), .stop_a(S_A), .stop_b(S_B),
    .go_a(G_A), .go_b(G_B), .char_tick(char_tick), .fc_req(fc_req),
    .fc_char(fc_char), .fc_ack(fc_ack)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    char_tick = 1'b1; @(negedge clk); char_tick = 1'b0;
  endtask

  task automatic ack();
    fc_ack = 1'b1; @(negedge clk); fc_ack = 1'b0;
  endtask

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int up_of(input int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 56 : 60;
  endfunction

  function automatic int lo_of(input int s);
    return (s == 0) ? 0 : (s == 1) ? 8 : (s == 2) ? 16 : 56;
  endfunction

  initial begin
    #(20 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_fill = '0; thr_sel = '0; lvl_en = 1'b1;
    pair_mode = 1'b0; char_tick = 1'b0; fc_ack = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", {1'b0, 7'(fc_req)}, 9'd0);

    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 4; s++) begin
        int up, lo;
        up = up_of(s); lo = lo_of(s);
        thr_sel = 2'(s); pair_mode = d[0];
        // R10: one below threshold starts nothing
        rx_fill = 7'(up - 1); cyc(1); tick(); tick(); cyc(1);
        chk("R10", 9'(fc_req), 9'd0);
        // R2 crossing, R11 stray ack while idle-side
        rx_fill = 7'(up); cyc(1);
        ack();
        tick();
        chk("R2", 9'(fc_req), 9'd0);
        tick();
        chk("R2", 9'(fc_req), 9'd1);
        chk("R11", {1'b0, fc_char}, {1'b0, S_A});
        cyc(3);
        chk("R5", {fc_req, fc_char}, {1'b1, S_A});
        ack();
        if (d == 1) begin
          chk("R4", {fc_req, fc_char}, {1'b1, S_B});
          ack();
        end
        chk("R4", 9'(fc_req), 9'd0);
        tick(); tick(); tick(); cyc(1);
        chk("R8", 9'(fc_req), 9'd0);
        // R6 hysteresis
        rx_fill = 7'(lo + 1); cyc(2);
        chk("R6", 9'(fc_req), 9'd0);
        rx_fill = 7'(lo); cyc(1);
        chk("R6", {fc_req, fc_char}, {1'b1, G_A});
        ack();
        if (d == 1) begin
          chk("R7", {fc_req, fc_char}, {1'b1, G_B});
          ack();
        end
        chk("R7", 9'(fc_req), 9'd0);
        // R9 cancel during the delay
        rx_fill = 7'(up); cyc(1);
        tick();
        rx_fill = 7'(lo); cyc(1);
        tick(); tick(); cyc(1);
        chk("R9", 9'(fc_req), 9'd0);
        rx_fill = '0; cyc(1);
      end
    end

    // R3 disabled
    lvl_en = 1'b0; rx_fill = 7'd64; cyc(1);
    tick(); tick(); tick(); cyc(1);
    chk("R3", 9'(fc_req), 9'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule